// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller for a pin count that is a multiple of 32. Software reaches it through a simple word bus with an address, a write strobe, write data and a combinational read-data return. Each pin has an input, an output value and an output enable. For each pin the controller provides the sampled input level, a direction bit, an output latch, rising and falling edge capture with a sticky status bit, and a 2-bit function select that goes out to the pad multiplexer.

Registers are grouped by feature. Each group holds one 32-bit word per bank of 32 pins. The function-select group holds two words per bank because every pin needs two bits. The output latch is never written directly. One group sets latch bits where the write data has ones, and another group clears them. Edge status bits are cleared by writing ones. A single interrupt line stays high while any status bit is set.

Pin inputs pass through a two-flop synchroniser. An edge is found by comparing the synchronised level with the level from the previous cycle.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, pin_out, pin_oe, pin_func and irq are all 0. The direction, output, enable, status and function registers all read 0.
- R2: Let NREG = NGPIO/32. The word index (bus_addr/4) is group×NREG + bank, and a pin's bit is pin mod 32. The groups are, in order: level 0, direction 1, output-set 2, output-clear 3, rising enable 4, falling enable 5, edge status 6 and function select 7. Function select spans 2×NREG words. Reads above the last word return 0, and writes there change nothing.
- R3: The level group returns each pin's input as it was two clock edges earlier. Writes to the level group are ignored.
- R4: Direction bit 1 makes the pin an output. pin_oe follows the direction register from the edge that writes it.
- R5: On the next edge, a 1 written to an output-set bit makes the pin's output 1, and a 1 written to an output-clear bit makes it 0. Zeros written to either group have no effect. A read of either group returns the output latch.
- R6: When a pin's rising enable bit is set, a 0-to-1 input change makes its status bit read 1 three edges after the change is applied, and not sooner.
- R7: When a pin's falling enable bit is set, a 1-to-0 input change sets the same status bit with the same latency. With both enables set, either edge is caught.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An edge captured on the same edge as a clear of that bit leaves the bit set.
- R9: irq is 1 exactly when at least one status bit is 1, in the same cycle.
- R10: Pin p has a 2-bit function field at word 7×NREG + p/16, bits (p mod 16)×2 upward. The field value appears on pin_func[2p+1:2p], and a value of 0 means plain GPIO.
- R11: An input transition whose edge type is not enabled for that pin leaves the status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | NGPIO | Asynchronous pin inputs |
| pin_out | output | NGPIO | Output latch |
| pin_oe | output | NGPIO | Output enable (direction) |
| pin_func | output | 2*NGPIO | Function select, two bits per pin |
| irq | output | 1 | High while any edge status bit is set |

## Verification
Register writes take effect on the edge that samples them, so read data and pin_out, pin_oe and pin_func are checked one edge after the write. A change on pin_in shows in the level group after two edges and in the edge status and irq after three. The directed checks wait exactly those counts and also check one edge early. The bench samples a quarter period after each rising edge, and it compares every output on every cycle against a behavioural model that advances at each edge. The case where an edge and a clear of the same bit arrive together is timed so that the write lands on the edge where the capture pulse is present.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int WORD_BITS  = 32;
    localparam int IDX_W      = 16;
    localparam int GRP_COUNT  = 8;
    localparam int FUNC_MULT  = 2;   // function group has two words per bank

    typedef enum logic [2:0] {
        GRP_LEVEL = 3'd0,
        GRP_DIR   = 3'd1,
        GRP_SET   = 3'd2,
        GRP_CLR   = 3'd3,
        GRP_RISE  = 3'd4,
        GRP_FALL  = 3'd5,
        GRP_STAT  = 3'd6,
        GRP_FUNC  = 3'd7
    } grp_e;

    typedef struct packed {
        logic             hit;
        grp_e             grp;
        logic [IDX_W-1:0] idx;
    } dec_t;

    // Word index -> group and word within group
    function automatic dec_t decode_word(input int unsigned word, input int unsigned nreg);
        dec_t d;
        d.hit = 1'b1;
        if (word < (GRP_COUNT - 1) * nreg) begin
            d.grp = grp_e'(3'(word / nreg));
            d.idx = IDX_W'(word % nreg);
        end else if (word < (GRP_COUNT - 1 + FUNC_MULT) * nreg) begin
            d.grp = GRP_FUNC;
            d.idx = IDX_W'(word - (GRP_COUNT - 1) * nreg);
        end else begin
            d.hit = 1'b0;
            d.grp = GRP_LEVEL;
            d.idx = '0;
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= pin_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign level_o = s2_q;
    assign rise_o  = s2_q & ~prev_q;
    assign fall_o  = prev_q & ~s2_q;

    // R3: level lags the pin by two edges
    p_level_lag_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (level_o == $past(pin_i, 2)))
        else $error("p_level_lag_r3");

endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] rise_en_i,
    input  logic [N-1:0] fall_en_i,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] fall_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o,
    output logic         any_o
);
    logic [N-1:0] status_q;
    logic [N-1:0] capture;

    assign capture = (rise_i & rise_en_i) | (fall_i & fall_en_i);

    // capture wins over a clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_i) | capture;
    end

    assign status_o = status_q;
    assign any_o    = |status_q;

    // R8: cleared bits without a capture read 0 next cycle
    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_i != '0) |=> ((status_q & $past(clr_i & ~capture)) == '0))
        else $error("p_w1c_r8");

    // R8: a captured edge is never lost
    p_capture_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (capture != '0) |=> ((status_q & $past(capture)) == $past(capture)))
        else $error("p_capture_kept_r8");

    // R6: status only appears from a capture or earlier status
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        (status_q != '0) |-> $past((status_q != '0) || (capture != '0)))
        else $error("p_no_spurious_r6");

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NGPIO  = 64,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NGPIO-1:0]     pin_in,
    output logic [NGPIO-1:0]     pin_out,
    output logic [NGPIO-1:0]     pin_oe,
    output logic [2*NGPIO-1:0]   pin_func,
    output logic                 irq
);
    localparam int NREG = NGPIO / WORD_BITS;
    localparam int NFW  = FUNC_MULT * NREG;

    dec_t dec;
    logic addr_lsb_unused;
    assign dec             = decode_word(32'(bus_addr[ADDR_W-1:2]), NREG);
    assign addr_lsb_unused = ^bus_addr[1:0];

    logic [NGPIO-1:0]   dir_q, out_q, ren_q, fen_q;
    logic [2*NGPIO-1:0] func_q;
    logic [NGPIO-1:0]   wr_set, wr_clr, stat_clr;
    logic [NGPIO-1:0]   level, rise, fall, status;
    logic               any_stat;

    gpio_sync #(.N(NGPIO)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_in),
        .level_o(level),
        .rise_o (rise),
        .fall_o (fall)
    );

    gpio_edge #(.N(NGPIO)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .rise_en_i(ren_q),
        .fall_en_i(fen_q),
        .rise_i   (rise),
        .fall_i   (fall),
        .clr_i    (stat_clr),
        .status_o (status),
        .any_o    (any_stat)
    );

    // write-one strobes per bank
    always_comb begin
        wr_set   = '0;
        wr_clr   = '0;
        stat_clr = '0;
        for (int b = 0; b < NREG; b++) begin
            if (bus_we && dec.hit && dec.idx == IDX_W'(b)) begin
                case (dec.grp)
                    GRP_SET:  wr_set[b*WORD_BITS +: WORD_BITS]   = bus_wdata;
                    GRP_CLR:  wr_clr[b*WORD_BITS +: WORD_BITS]   = bus_wdata;
                    GRP_STAT: stat_clr[b*WORD_BITS +: WORD_BITS] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            out_q  <= '0;
            ren_q  <= '0;
            fen_q  <= '0;
            func_q <= '0;
        end else begin
            out_q <= (out_q | wr_set) & ~wr_clr;
            for (int b = 0; b < NREG; b++) begin
                if (bus_we && dec.hit && dec.idx == IDX_W'(b)) begin
                    case (dec.grp)
                        GRP_DIR:  dir_q[b*WORD_BITS +: WORD_BITS] <= bus_wdata;
                        GRP_RISE: ren_q[b*WORD_BITS +: WORD_BITS] <= bus_wdata;
                        GRP_FALL: fen_q[b*WORD_BITS +: WORD_BITS] <= bus_wdata;
                        default: ;
                    endcase
                end
            end
            for (int w = 0; w < NFW; w++) begin
                if (bus_we && dec.hit && dec.grp == GRP_FUNC && dec.idx == IDX_W'(w))
                    func_q[w*WORD_BITS +: WORD_BITS] <= bus_wdata;
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (dec.hit) begin
            if (dec.grp == GRP_FUNC) begin
                for (int w = 0; w < NFW; w++)
                    if (dec.idx == IDX_W'(w)) bus_rdata = func_q[w*WORD_BITS +: WORD_BITS];
            end else begin
                for (int b = 0; b < NREG; b++) begin
                    if (dec.idx == IDX_W'(b)) begin
                        case (dec.grp)
                            GRP_LEVEL:         bus_rdata = level[b*WORD_BITS +: WORD_BITS];
                            GRP_DIR:           bus_rdata = dir_q[b*WORD_BITS +: WORD_BITS];
                            GRP_SET, GRP_CLR:  bus_rdata = out_q[b*WORD_BITS +: WORD_BITS];
                            GRP_RISE:          bus_rdata = ren_q[b*WORD_BITS +: WORD_BITS];
                            GRP_FALL:          bus_rdata = fen_q[b*WORD_BITS +: WORD_BITS];
                            GRP_STAT:          bus_rdata = status[b*WORD_BITS +: WORD_BITS];
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    assign pin_out  = out_q;
    assign pin_oe   = dir_q;
    assign pin_func = func_q;
    assign irq      = any_stat;

    // R5: set strobes drive outputs high next cycle
    p_set_high_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_set != '0) |=> ((pin_out & $past(wr_set)) == $past(wr_set)))
        else $error("p_set_high_r5");

    // R5: clear strobes drive outputs low next cycle
    p_clr_low_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_clr != '0) |=> ((pin_out & $past(wr_clr)) == '0))
        else $error("p_clr_low_r5");

    // R5: no strobe, no change
    p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_set == '0 && wr_clr == '0) |=> $stable(pin_out))
        else $error("p_out_hold_r5");

    // R4: a direction write to bank 0 shows on pin_oe
    p_dir_bank0_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && dec.hit && dec.grp == GRP_DIR && dec.idx == '0)
            |=> (pin_oe[WORD_BITS-1:0] == $past(bus_wdata)))
        else $error("p_dir_bank0_r4");

    // R9: irq rises only after a capture
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past((rise & ren_q) != '0 || (fall & fen_q) != '0))
        else $error("p_irq_cause_r9");

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 64;
    localparam int NREG = N / 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     bus_addr = '0;
    logic           bus_we = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [N-1:0]   pin_in = '0;
    logic [N-1:0]   pin_out, pin_oe;
    logic [2*N-1:0] pin_func;
    logic           irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_ctrl #(.NGPIO(N), .ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func), .irq(irq)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [N-1:0]   m_s1, m_s2, m_prev, m_dir, m_out, m_ren, m_fen, m_stat;
    logic [2*N-1:0] m_func;

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        int wd = int'(a >> 2);
        int b;
        if (wd < 7*NREG) begin
            b = wd % NREG;
            case (wd / NREG)
                0: return m_s2[b*32 +: 32];
                1: return m_dir[b*32 +: 32];
                2, 3: return m_out[b*32 +: 32];
                4: return m_ren[b*32 +: 32];
                5: return m_fen[b*32 +: 32];
                default: return m_stat[b*32 +: 32];
            endcase
        end else if (wd < 9*NREG) return m_func[(wd - 7*NREG)*32 +: 32];
        return 32'h0;
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        int wd = int'(a >> 2);
        if (wd >= 9*NREG) return "R2 unmapped read";
        if (wd >= 7*NREG) return "R10 function read";
        case (wd / NREG)
            0: return "R3 level read";
            1: return "R4 direction read";
            2, 3: return "R5 output read";
            4, 5: return "R6 enable read";
            default: return "R8 status read";
        endcase
    endfunction

    always @(posedge clk) begin
        logic [N-1:0] setv;
        logic [N-1:0] nstat;
        int wd, b;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_dir = '0; m_out = '0;
            m_ren = '0; m_fen = '0; m_stat = '0; m_func = '0;
        end else begin
            for (int i = 0; i < N; i++)
                setv[i] = (m_ren[i] && !m_prev[i] && m_s2[i]) || (m_fen[i] && m_prev[i] && !m_s2[i]);
            nstat = m_stat;
            wd = int'(bus_addr >> 2);
            b  = wd % NREG;
            if (bus_we && wd < 7*NREG) begin
                case (wd / NREG)
                    1: m_dir[b*32 +: 32] = bus_wdata;
                    2: m_out[b*32 +: 32] = m_out[b*32 +: 32] | bus_wdata;
                    3: m_out[b*32 +: 32] = m_out[b*32 +: 32] & ~bus_wdata;
                    4: m_ren[b*32 +: 32] = bus_wdata;
                    5: m_fen[b*32 +: 32] = bus_wdata;
                    6: nstat[b*32 +: 32] = nstat[b*32 +: 32] & ~bus_wdata;
                    default: ;
                endcase
            end else if (bus_we && wd < 9*NREG) begin
                m_func[(wd - 7*NREG)*32 +: 32] = bus_wdata;
            end
            m_stat = nstat | setv;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin_in;
        end
        #(CLK_PERIOD/4);
        chk(rd_tag(bus_addr), 128'(bus_rdata), 128'(model_rd(bus_addr)));
        chk("R5 pin_out model", 128'(pin_out), 128'(m_out));
        chk("R4 pin_oe model", 128'(pin_oe), 128'(m_dir));
        chk("R10 pin_func model", pin_func, m_func);
        chk("R9 irq model", 128'(irq), 128'(m_stat != '0));
    end

    // ---------------- directed stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] r;
        @(negedge clk);
        tick(3);
        chk("R1 reset pin_out", 128'(pin_out), 128'h0);
        chk("R1 reset pin_oe", 128'(pin_oe), 128'h0);
        chk("R1 reset pin_func", pin_func, 128'h0);
        chk("R1 reset irq", 128'(irq), 128'h0);
        rst = 1'b0;
        tick(1);
        rd(8'h08, r); chk("R1 dir after reset", 128'(r), 128'h0);
        rd(8'h30, r); chk("R1 status after reset", 128'(r), 128'h0);

        // R3 level path, two-edge latency
        pin_in = 64'hA5A5_0000_FFFF_1234;
        rd(8'h00, r);
        tick(1); rd(8'h00, r); chk("R3 level one edge early", 128'(r), 128'h0);
        tick(1); rd(8'h00, r); chk("R3 level bank0", 128'(r), 128'hFFFF_1234);
        rd(8'h04, r); chk("R2 level bank1", 128'(r), 128'hA5A5_0000);
        bus_wr(8'h00, 32'h0); rd(8'h00, r); chk("R3 level write ignored", 128'(r), 128'hFFFF_1234);
        rd(8'h30, r); chk("R11 no status without enables", 128'(r), 128'h0);

        // R4 direction
        bus_wr(8'h0C, 32'hF0F0_0000);
        chk("R4 pin_oe bank1", 128'(pin_oe), 128'(64'hF0F0_0000_0000_0000));
        rd(8'h08, r); chk("R2 dir bank0 distinct", 128'(r), 128'h0);

        // R5 set / clear
        bus_wr(8'h10, 32'h0000_00FF);
        chk("R5 set", 128'(pin_out), 128'h0FF);
        bus_wr(8'h18, 32'h0000_000F);
        chk("R5 clear", 128'(pin_out), 128'h0F0);
        bus_wr(8'h10, 32'h0); bus_wr(8'h18, 32'h0);
        chk("R5 zero writes", 128'(pin_out), 128'h0F0);
        rd(8'h10, r); chk("R5 set group reads latch", 128'(r), 128'h0F0);
        bus_wr(8'h14, 32'h8000_0001);
        rd(8'h1C, r); chk("R5 bank1 latch", 128'(r), 128'h8000_0001);

        // R6/R7 edge capture
        bus_wr(8'h20, 32'h0000_0021);
        bus_wr(8'h28, 32'h0000_0020);
        bus_wr(8'h2C, 32'h0000_0001);
        pin_in[0] = 1'b1;
        tick(2); rd(8'h30, r); chk("R6 status not yet", 128'(r), 128'h0);
        chk("R9 irq not yet", 128'(irq), 128'h0);
        tick(1); rd(8'h30, r); chk("R6 rise captured", 128'(r), 128'h1);
        chk("R9 irq high", 128'(irq), 128'h1);
        pin_in[5] = 1'b0;
        tick(3); rd(8'h30, r); chk("R7 fall captured", 128'(r), 128'h21);

        // R8 clear
        bus_wr(8'h30, 32'h20); rd(8'h30, r); chk("R8 w1c", 128'(r), 128'h1);
        bus_wr(8'h30, 32'h0);  rd(8'h30, r); chk("R8 zero write", 128'(r), 128'h1);

        // R11 rising on falling-only pin
        pin_in[32] = 1'b1;
        tick(3); rd(8'h34, r); chk("R11 disabled edge", 128'(r), 128'h0);
        pin_in[32] = 1'b0;
        tick(3); rd(8'h34, r); chk("R7 fall bank1", 128'(r), 128'h1);
        bus_wr(8'h30, 32'hFFFF_FFFF); bus_wr(8'h34, 32'hFFFF_FFFF);
        chk("R9 irq low after clear", 128'(irq), 128'h0);

        // R8 same-edge capture and clear
        pin_in[0] = 1'b0; tick(3);
        pin_in[0] = 1'b1; tick(3);
        pin_in[0] = 1'b0; tick(3);
        pin_in[0] = 1'b1; tick(2);
        bus_wr(8'h30, 32'h1);
        rd(8'h30, r); chk("R8 capture beats clear", 128'(r), 128'h1);
        bus_wr(8'h30, 32'h1);
        rd(8'h30, r); chk("R8 clear after race", 128'(r), 128'h0);

        // R7 both edges on pin 5
        pin_in[5] = 1'b1; tick(3);
        rd(8'h30, r); chk("R7 both-enable rise", 128'(r), 128'h20);
        bus_wr(8'h30, 32'h20);
        pin_in[5] = 1'b0; tick(3);
        rd(8'h30, r); chk("R7 both-enable fall", 128'(r), 128'h20);

        // R10 function select
        bus_wr(8'h3C, 32'h0000_000C);
        chk("R10 pin 17 field", 128'(pin_func[35:34]), 128'h3);
        bus_wr(8'h44, 32'h8000_0000);
        chk("R10 pin 63 field", 128'(pin_func[127:126]), 128'h2);
        rd(8'h44, r); chk("R10 read back", 128'(r), 128'h8000_0000);

        // R2 unmapped
        bus_wr(8'h48, 32'hFFFF_FFFF);
        rd(8'h48, r); chk("R2 unmapped read", 128'(r), 128'h0);
        rd(8'hFC, r); chk("R2 top address", 128'(r), 128'h0);

        // random traffic, checked by the model each cycle
        for (int k = 0; k < 600; k++) begin
            pin_in = {$urandom, $urandom};
            if ($urandom_range(0, 2) == 0)
                bus_wr(8'($urandom_range(0, 20) * 4), $urandom);
            else begin
                bus_addr = 8'($urandom_range(0, 20) * 4);
                tick(1);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R1 watchdog act=timeout exp=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule